// File: doc/BRIEF.md
# Link Receiver Output State Controller

This block sits on the parallel side of a serial-link receiver. It sets the pad state of every output group: the lock flag, the pass flag, the parallel pixel data, the combined GPIO/audio lines and the pixel clock. Each group is either released (high impedance), driven low, held at an earlier value or carrying live recovered data. The choice comes from a joint table over the active-low power-down input, the effective output enable, the effective output-state select and whether the link is locked to an active stream.

Output enable, state select and strobe-edge select each come from a pin, or from a register bit when that field's register-select bit is set. When the stream is lost and outputs are enabled, the pixel clock can come from an internal oscillator. That oscillator is a programmable divider on the free-running block clock. A low-frequency mode request is latched only while the receiver is powered down. Pads are modelled as a value plus a separate drive-enable per group. The clock-recovery loop is outside the block and appears only as the `link_lock` and `link_active` inputs.

Top module: `lrx_out_ctrl`

## Requirements
- R1: While `pd_n` is 0, every drive enable (`lock_oe`, `pass_oe`, `data_oe`, `aux_oe`, `pclk_oe`) is 0.
- R2: The effective enable, state select and edge select each equal the register bit when the matching `*_sel` bit is 1, and the pin otherwise.
- R3: With `pd_n`=1 and effective enable 0, the pass, data, aux and clock groups are released when state select is 0, and are driven to 0 when it is 1. The lock flag is driven with the lock status if locked, and released otherwise.
- R4: Internal lock status is 0 after reset. It becomes 1 one clock edge after `pd_n`, `link_lock` and `link_active` are all 1. It returns to 0 one edge after any of them is 0.
- R5: With `pd_n`=1, effective enable 1 and status unlocked, `lock_o`, `pass_o` and `data_o` are driven to 0.
- R6: With `pd_n`=1, effective enable 1 and status locked, `lock_o`=1 and `pass_o`=1. `data_o` equals `rx_data` and `aux_o` equals `rx_aux`, all driven.
- R7: In the unlocked, enabled state, `aux_o` is driven with the `rx_aux` value captured at the last clock edge where the block was in the live state of R6 (0 after reset).
- R8: In the unlocked, enabled state, `pclk_o` is driven 0 when `reg_osc_en`=0. When `reg_osc_en`=1 it carries the oscillator, whose level holds for `reg_osc_div`+1 cycles between toggles.
- R9: In the live state, `pclk_o` equals `rx_pclk` when effective edge select is 1 (rising-edge strobe), and equals its inverse when it is 0 (falling-edge strobe).
- R10: `lf_mode_o` is 0 after reset. It takes `lfm_req` only at clock edges where `pd_n` is 0, and keeps its value while `pd_n` is 1.
- R11: After reset the oscillator output is 0, and it is held at 0 while `reg_osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock, also the oscillator source |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down, active low |
| oe_pin | input | 1 | Output enable from pin |
| oss_pin | input | 1 | Output-state select from pin |
| edge_pin | input | 1 | Strobe-edge select from pin |
| reg_oe | input | 1 | Register value for output enable |
| reg_oe_sel | input | 1 | 1 = use `reg_oe` |
| reg_oss | input | 1 | Register value for state select |
| reg_oss_sel | input | 1 | 1 = use `reg_oss` |
| reg_edge | input | 1 | Register value for edge select |
| reg_edge_sel | input | 1 | 1 = use `reg_edge` |
| reg_osc_en | input | 1 | Enable oscillator fallback clock |
| reg_osc_div | input | 3 | Oscillator half-period minus one, in clocks |
| lfm_req | input | 1 | Requested low-frequency mode |
| link_lock | input | 1 | Clock recovery reports lock |
| link_active | input | 1 | Serial stream is toggling |
| rx_data | input | 24 | Recovered pixel data |
| rx_aux | input | 6 | Recovered GPIO and audio lines |
| rx_pclk | input | 1 | Recovered pixel clock level |
| lock_o | output | 1 | Lock flag value |
| lock_oe | output | 1 | Lock flag drive enable |
| pass_o | output | 1 | Pass flag value |
| pass_oe | output | 1 | Pass flag drive enable |
| data_o | output | 24 | Pixel data value |
| data_oe | output | 1 | Pixel data drive enable |
| aux_o | output | 6 | GPIO/audio value |
| aux_oe | output | 1 | GPIO/audio drive enable |
| pclk_o | output | 1 | Pixel clock value |
| pclk_oe | output | 1 | Pixel clock drive enable |
| lf_mode_o | output | 1 | Latched low-frequency mode |

## Verification
The assertions assume that `reg_osc_div` and `reg_osc_en` do not change while the oscillator half-period check is in effect. They also assume that the lock inputs come in synchronous to `clk`. The random phase draws all table inputs freely. Its pixel clock check is waived in the cycles where the model expects the oscillator, because oscillator phase is not modelled there. Oscillator timing is checked only in directed runs, where the divider setting is held constant after a disabled cycle.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    localparam int DATA_W = 24;
    localparam int AUX_W  = 6;
    localparam int DIV_W  = 3;

    // ALT: held value for aux, oscillator for the clock group
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_LOW  = 2'd1,
        DRV_ALT  = 2'd2,
        DRV_LIVE = 2'd3
    } drv_e;

    typedef struct packed {
        logic lock_en;
        drv_e body;
        drv_e aux;
        drv_e clk;
    } drv_plan_t;

    function automatic logic pick(input logic sel, input logic regv, input logic pin);
        return sel ? regv : pin;
    endfunction

    function automatic drv_plan_t plan_outputs(
        input logic pd_n, input logic oe, input logic oss,
        input logic locked, input logic osc_en);
        drv_plan_t p;
        p.lock_en = pd_n & (oe | locked);
        if (!pd_n) begin
            p.body = DRV_OFF; p.aux = DRV_OFF; p.clk = DRV_OFF;
        end else if (!oe) begin
            p.body = oss ? DRV_LOW : DRV_OFF;
            p.aux  = p.body;
            p.clk  = p.body;
        end else if (locked) begin
            p.body = DRV_LIVE; p.aux = DRV_LIVE; p.clk = DRV_LIVE;
        end else begin
            p.body = DRV_LOW;
            p.aux  = DRV_ALT;
            p.clk  = osc_en ? DRV_ALT : DRV_LOW;
        end
        return p;
    endfunction

endpackage

// File: rtl/lrx_ctl_regs.sv
module lrx_ctl_regs (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    input  logic link_lock,
    input  logic link_active,
    input  logic lfm_req,
    output logic locked_q,
    output logic lf_mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q  <= 1'b0;
            lf_mode_q <= 1'b0;
        end else begin
            locked_q <= pd_n & link_lock & link_active;
            if (!pd_n) lf_mode_q <= lfm_req;
        end
    end

    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (rst)
        !(pd_n && link_lock && link_active) |=> !locked_q); // R4
    AST_LF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        pd_n |=> $stable(lf_mode_q)); // R10
endmodule

// File: rtl/lrx_osc_div.sv
module lrx_osc_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic [DIV_W-1:0] div,
    output logic             osc_q
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !osc_en) begin
            cnt_q <= '0;
            osc_q <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            osc_q <= ~osc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_OSC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> !osc_q); // R11
    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (osc_en && $past(osc_en) && $stable(div) && cnt_q != '0) |-> $stable(osc_q)); // R8
endmodule

// File: rtl/lrx_pad_drv.sv
module lrx_pad_drv
    import lrx_pkg::*;
#(
    parameter int DW = 24,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  drv_plan_t     plan,
    input  logic          locked,
    input  logic          edge_rise,
    input  logic          osc,
    input  logic [DW-1:0] rx_data,
    input  logic [AW-1:0] rx_aux,
    input  logic          rx_pclk,
    output logic          lock_o,
    output logic          lock_oe,
    output logic          pass_o,
    output logic          pass_oe,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic [AW-1:0] aux_o,
    output logic          aux_oe,
    output logic          pclk_o,
    output logic          pclk_oe
);
    logic [AW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)                     hold_q <= '0;
        else if (plan.aux == DRV_LIVE) hold_q <= rx_aux;
    end

    always_comb begin
        lock_oe = plan.lock_en;
        lock_o  = plan.lock_en & locked;
        pass_oe = (plan.body != DRV_OFF);
        pass_o  = (plan.body == DRV_LIVE);
        data_oe = (plan.body != DRV_OFF);
        data_o  = (plan.body == DRV_LIVE) ? rx_data : '0;
        aux_oe  = (plan.aux != DRV_OFF);
        unique case (plan.aux)
            DRV_LIVE: aux_o = rx_aux;
            DRV_ALT:  aux_o = hold_q;
            default:  aux_o = '0;
        endcase
        pclk_oe = (plan.clk != DRV_OFF);
        unique case (plan.clk)
            DRV_LIVE: pclk_o = edge_rise ? rx_pclk : ~rx_pclk;
            DRV_ALT:  pclk_o = osc;
            default:  pclk_o = 1'b0;
        endcase
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (plan.aux == DRV_ALT && $past(plan.aux) == DRV_ALT) |-> $stable(aux_o)); // R7
    AST_LOCK_NOT_LIVE: assert property (@(posedge clk) disable iff (rst)
        (lock_oe && !lock_o) |-> (plan.body != DRV_LIVE)); // R5
endmodule

// File: rtl/lrx_out_ctrl.sv
module lrx_out_ctrl
    import lrx_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = AUX_W,
    parameter int DIVW  = DIV_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd_n,
    input  logic            oe_pin,
    input  logic            oss_pin,
    input  logic            edge_pin,
    input  logic            reg_oe,
    input  logic            reg_oe_sel,
    input  logic            reg_oss,
    input  logic            reg_oss_sel,
    input  logic            reg_edge,
    input  logic            reg_edge_sel,
    input  logic            reg_osc_en,
    input  logic [DIVW-1:0] reg_osc_div,
    input  logic            lfm_req,
    input  logic            link_lock,
    input  logic            link_active,
    input  logic [DW-1:0]   rx_data,
    input  logic [AW-1:0]   rx_aux,
    input  logic            rx_pclk,
    output logic            lock_o,
    output logic            lock_oe,
    output logic            pass_o,
    output logic            pass_oe,
    output logic [DW-1:0]   data_o,
    output logic            data_oe,
    output logic [AW-1:0]   aux_o,
    output logic            aux_oe,
    output logic            pclk_o,
    output logic            pclk_oe,
    output logic            lf_mode_o
);
    logic      oe_eff, oss_eff, edge_eff;
    logic      locked_q, osc_q;
    drv_plan_t plan;

    assign oe_eff   = pick(reg_oe_sel,   reg_oe,   oe_pin);
    assign oss_eff  = pick(reg_oss_sel,  reg_oss,  oss_pin);
    assign edge_eff = pick(reg_edge_sel, reg_edge, edge_pin);
    assign plan     = plan_outputs(pd_n, oe_eff, oss_eff, locked_q, reg_osc_en);

    lrx_ctl_regs u_regs (
        .clk(clk), .rst(rst), .pd_n(pd_n), .link_lock(link_lock),
        .link_active(link_active), .lfm_req(lfm_req),
        .locked_q(locked_q), .lf_mode_q(lf_mode_o)
    );

    lrx_osc_div #(.DIV_W(DIVW)) u_osc (
        .clk(clk), .rst(rst), .osc_en(reg_osc_en), .div(reg_osc_div), .osc_q(osc_q)
    );

    lrx_pad_drv #(.DW(DW), .AW(AW)) u_pad (
        .clk(clk), .rst(rst), .plan(plan), .locked(locked_q), .edge_rise(edge_eff),
        .osc(osc_q), .rx_data(rx_data), .rx_aux(rx_aux), .rx_pclk(rx_pclk),
        .lock_o(lock_o), .lock_oe(lock_oe), .pass_o(pass_o), .pass_oe(pass_oe),
        .data_o(data_o), .data_oe(data_oe), .aux_o(aux_o), .aux_oe(aux_oe),
        .pclk_o(pclk_o), .pclk_oe(pclk_oe)
    );

    AST_PD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !pd_n |-> !(lock_oe | pass_oe | data_oe | aux_oe | pclk_oe)); // R1
    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (pd_n && !oe_eff && !oss_eff) |-> !(pass_oe | data_oe | aux_oe | pclk_oe)); // R3
    AST_LIVE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (pd_n && oe_eff && locked_q) |-> (lock_o && pass_o && data_oe)); // R6
    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
        (lock_oe && lock_o && !$past(lock_o)) |-> $past(link_lock && link_active)); // R4
endmodule

// File: tb/lrx_out_ctrl_test.sv
`timescale 1ns/1ps
module lrx_out_ctrl_test;
    localparam int DW = 24;
    localparam int AW = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic pd_n, oe_pin, oss_pin, edge_pin, reg_oe, reg_oe_sel, reg_oss, reg_oss_sel;
    logic reg_edge, reg_edge_sel, reg_osc_en, lfm_req, link_lock, link_active, rx_pclk;
    logic [2:0] reg_osc_div;
    logic [DW-1:0] rx_data;
    logic [AW-1:0] rx_aux;
    logic lock_o, lock_oe, pass_o, pass_oe, data_oe, aux_oe, pclk_o, pclk_oe, lf_mode_o;
    logic [DW-1:0] data_o;
    logic [AW-1:0] aux_o;

    int checks = 0, fails = 0;
    logic m_locked = 1'b0, m_lf = 1'b0;
    logic [AW-1:0] m_hold = '0;

    always #2.5 clk = ~clk;

    lrx_out_ctrl uut (.*);

    function automatic logic e_oe();   return reg_oe_sel   ? reg_oe   : oe_pin;   endfunction
    function automatic logic e_oss();  return reg_oss_sel  ? reg_oss  : oss_pin;  endfunction
    function automatic logic e_edge(); return reg_edge_sel ? reg_edge : edge_pin; endfunction
    function automatic logic m_live(); return pd_n & e_oe() & m_locked; endfunction

    // reference state, updated from requirements R4, R7, R10
    always @(posedge clk) begin
        if (rst) begin
            m_locked <= 1'b0; m_lf <= 1'b0; m_hold <= '0;
        end else begin
            if (m_live()) m_hold <= rx_aux;
            m_locked <= pd_n & link_lock & link_active;
            if (!pd_n) m_lf <= lfm_req;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // expected pad state from R1, R3, R5, R6, R7, R8, R9
    task automatic check_all(input logic skip_clk);
        logic l_oe, l_v, g_oe, p_v, c_oe, c_v;
        logic [DW-1:0] d_v;
        logic [AW-1:0] a_v;
        l_oe = pd_n & (e_oe() | m_locked);
        l_v = l_oe & m_locked;
        if (!pd_n) begin
            g_oe = 0; p_v = 0; d_v = '0; a_v = '0; c_oe = 0; c_v = 0;
        end else if (!e_oe()) begin
            g_oe = e_oss(); p_v = 0; d_v = '0; a_v = '0; c_oe = e_oss(); c_v = 0;
        end else if (m_locked) begin
            g_oe = 1; p_v = 1; d_v = rx_data; a_v = rx_aux; c_oe = 1;
            c_v = e_edge() ? rx_pclk : ~rx_pclk;
        end else begin
            g_oe = 1; p_v = 0; d_v = '0; a_v = m_hold; c_oe = 1; c_v = 0;
        end
        chk("R1/R3 lock_oe", 32'(lock_oe), 32'(l_oe));
        chk("R4/R5 lock_o", 32'(lock_o), 32'(l_v));
        chk("R3 pass_oe", 32'(pass_oe), 32'(g_oe));
        chk("R5/R6 pass_o", 32'(pass_o), 32'(p_v));
        chk("R3 data_oe", 32'(data_oe), 32'(g_oe));
        chk("R6 data_o", 32'(data_o), 32'(d_v));
        chk("R3 aux_oe", 32'(aux_oe), 32'(g_oe));
        chk("R7 aux_o", 32'(aux_o), 32'(a_v));
        chk("R1 pclk_oe", 32'(pclk_oe), 32'(c_oe));
        if (!skip_clk) chk("R8/R9 pclk_o", 32'(pclk_o), 32'(c_v));
        chk("R10 lf_mode_o", 32'(lf_mode_o), 32'(m_lf));
    endtask

    task automatic randomize_inputs(input logic fix_pins);
        pd_n = ($urandom % 10) != 0;
        link_lock = ($urandom % 5) != 0;
        link_active = ($urandom % 5) != 0;
        rx_data = DW'($urandom); rx_aux = AW'($urandom); rx_pclk = 1'($urandom);
        lfm_req = 1'($urandom);
        reg_osc_en = 1'($urandom); reg_osc_div = 3'($urandom);
        if (!fix_pins) begin
            {oe_pin, oss_pin, edge_pin} = 3'($urandom);
            {reg_oe, reg_oe_sel, reg_oss, reg_oss_sel, reg_edge, reg_edge_sel} = 6'($urandom);
            if (($urandom % 4) != 0) begin oe_pin = 1; reg_oe_sel = 0; end
        end
    endtask

    task automatic osc_run(input logic [2:0] d);
        logic prev;
        int run, seen;
        @(negedge clk);
        pd_n = 1; oe_pin = 1; reg_oe_sel = 0; link_lock = 0; reg_osc_en = 0;
        @(negedge clk); @(negedge clk);
        #1 chk("R8 pclk low while osc off", 32'(pclk_o), 32'd0);
        reg_osc_en = 1; reg_osc_div = d;
        prev = pclk_o; run = 0; seen = 0;
        for (int i = 0; i < 6 * (int'(d) + 1) + 4; i++) begin
            @(negedge clk); #1;
            if (pclk_o !== prev) begin
                if (seen > 0) chk("R8 osc half period", 32'(run), 32'(int'(d) + 1));
                seen++; run = 1; prev = pclk_o;
            end else run++;
        end
        chk("R8 osc toggles seen", 32'(seen >= 3), 32'd1);
        reg_osc_en = 0;
    endtask

    initial begin
        #1000000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        pd_n = 0; {oe_pin, oss_pin, edge_pin} = 3'b110;
        {reg_oe, reg_oe_sel, reg_oss, reg_oss_sel, reg_edge, reg_edge_sel} = '0;
        reg_osc_en = 0; reg_osc_div = 0; lfm_req = 1; link_lock = 1; link_active = 1;
        rx_data = '0; rx_aux = '0; rx_pclk = 0;
        repeat (3) @(negedge clk);
        lfm_req = 0; rst = 0;
        #1;
        // R11 / reset state: everything released, lock status clear
        chk("R1 reset release", 32'({lock_oe, pass_oe, data_oe, aux_oe, pclk_oe}), 32'd0);
        chk("R10 reset lf", 32'(lf_mode_o), 32'd0);

        // R4: lock rises one edge after all inputs high
        @(negedge clk); pd_n = 1; rx_data = 24'hA5C3F0; rx_aux = 6'h2D;
        #1 chk("R4 lock not yet", 32'(lock_o), 32'd0);
        @(negedge clk); #1;
        chk("R4 lock after one edge", 32'(lock_o), 32'd1);
        chk("R6 data live", 32'(data_o), 32'hA5C3F0);
        // R7: drop active stream; aux holds last live value
        link_active = 0; rx_aux = 6'h11;
        @(negedge clk); rx_aux = 6'h3F; #1;
        chk("R4 lock dropped", 32'(lock_o), 32'd0);
        chk("R7 aux held", 32'(aux_o), 32'h11);
        chk("R5 data low", 32'({data_oe, data_o == '0}), 32'd3);
        // R10: request ignored while powered up
        lfm_req = 1; @(negedge clk); #1;
        chk("R10 lf ignored when up", 32'(lf_mode_o), 32'd0);
        pd_n = 0; @(negedge clk); #1;
        chk("R10 lf taken in power-down", 32'(lf_mode_o), 32'd1);
        // R2: register override of enable/select
        pd_n = 1; oe_pin = 1; reg_oe = 0; reg_oe_sel = 1; reg_oss = 1; reg_oss_sel = 1;
        @(negedge clk); #1;
        chk("R2 override forces low drive", 32'({data_oe, pass_oe, pclk_o}), 32'b110);
        reg_oss = 0; #1;
        chk("R2/R3 override release", 32'({data_oe, aux_oe, pclk_oe}), 32'd0);
        reg_oe_sel = 0; reg_oss_sel = 0;

        osc_run(3'd0);
        osc_run(3'd3);
        osc_run(3'd7);

        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            randomize_inputs(i % 3 == 0);
            #1 check_all(pd_n && e_oe() && !m_locked && reg_osc_en);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule